// File: doc/BRIEF.md
# I2C Register-Bank Target

This block is a bus target for a two-wire serial bus. It holds a bank of 256 byte-wide registers that a bus controller reads and writes. After its address with the direction bit cleared, the controller sends an index byte that loads an internal register pointer. Any further bytes in that transfer are stored at the pointer, one after another. To read, the controller issues a repeated START, or a new START, and addresses the block with the direction bit set. The block then returns the bytes starting at the pointer.

Everything runs on one fast system clock. Both bus lines are oversampled through synchronizers. Rising and falling edges of both lines become single-cycle enables, and START and STOP are recognised from the data line changing while the clock line is high. The data line is never driven high. The block only asserts an output enable that pulls the line low, and leaves it released otherwise.

Top module: `i2c_regbank_target`

## Requirements
- R1: While reset is asserted and after it, every register reads as 0x00, the pointer is 0 and `sda_oe` is 0 (line released).
- R2: When the first byte after START carries `dev_addr` in bits 7..1 (MSB first on the wire), the target pulls SDA low through the whole high phase of the ninth clock.
- R3: A first byte whose bits 7..1 differ from `dev_addr` gets no acknowledge, and every byte up to the next START or STOP is ignored: no acknowledge, no register change, no pointer change.
- R4: In a transfer whose address byte has bit 0 = 0 (write), the next byte loads the pointer and is acknowledged.
- R5: Each later byte of a write transfer is stored at the pointer and acknowledged, and the pointer then steps by one, from 0xFF wrapping to 0x00.
- R6: After an address byte with bit 0 = 1 (read), the target sends the register at the pointer, MSB first, with each bit stable on SDA while SCL is high.
- R7: After each byte sent, the pointer steps by one with wrap. A controller acknowledge (SDA low on the ninth clock) starts the next byte, and a not-acknowledge ends the read with SDA released.
- R8: `sda_oe` changes only while the synchronized SCL is low, and it is 0 whenever the target is not acknowledging or sending a 0 bit.
- R9: A START at any point abandons the byte in progress without storing it and begins a new address phase. A STOP returns the target to idle. Both leave SDA released.
- R10: The pointer is kept across transfers, so a read with no index byte continues from where the last write or read left it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state is clocked by it |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| dev_addr | input | 7 | Target address compared with the first byte |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The hardest case to reach from the ports is a START that lands partway through a data byte. At that point the target holds a half-filled shift register and a live pointer, and neither may leak into the register bank. The stimulus sets the pointer, clocks only three bits of the next byte and then raises a repeated START. A read from the same index follows, and it must return the old contents. The pointer-wrap and foreign-address cases are also reached only through full transfers, and each is confirmed by a later read-back.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
   typedef enum logic [3:0] {
      ST_IDLE,
      ST_ADDR,
      ST_ADDR_ACK,
      ST_REG,
      ST_REG_ACK,
      ST_WDAT,
      ST_WDAT_ACK,
      ST_RDAT,
      ST_RACK
   } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
   parameter int STAGES = 2,
   parameter bit FILTER = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin,
   output logic lvl,
   output logic rise,
   output logic fall
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("i2c_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain;
   logic              lvl_d, lvl_q, prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], pin};
   end

   generate
      if (FILTER) begin : g_filt
         always_comb lvl_d = (chain[STAGES-1] == chain[STAGES-2]) ? chain[STAGES-1] : lvl_q;
      end else begin : g_plain
         always_comb lvl_d = chain[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q  <= 1'b1;
         prev_q <= 1'b1;
      end else begin
         lvl_q  <= lvl_d;
         prev_q <= lvl_q;
      end
   end

   assign lvl  = lvl_q;
   assign rise = lvl_q & ~prev_q;
   assign fall = ~lvl_q & prev_q;
endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 256,
   localparam int IDX_W = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  widx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  ridx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem [DEPTH];

   generate
      for (genvar g = 0; g < DEPTH; g++) begin : g_cell
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          mem[g] <= '0;
            else if (we && widx == IDX_W'(g))    mem[g] <= wdata;
         end
      end
   endgenerate

   assign rdata = mem[ridx];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
   import i2c_tgt_pkg::*;
#(
   parameter int ADDR_W = 7,
   parameter int DATA_W = 8,
   parameter int IDX_W  = 8,
   localparam int CNT_W = $clog2(DATA_W + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_lvl,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W-1:0] dev_addr,
   input  logic [DATA_W-1:0] rd_data,
   output logic              we,
   output logic [IDX_W-1:0]  widx,
   output logic [DATA_W-1:0] wdata,
   output logic [IDX_W-1:0]  ptr,
   output logic              sda_oe,
   output logic              idle,
   output logic              rd_mode
);
   localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DATA_W);

   tgt_state_e        st;
   logic [DATA_W-1:0] sh, txb;
   logic [CNT_W-1:0]  cnt;
   logic              rw, mack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= ST_IDLE;
         sh     <= '0;
         txb    <= '0;
         cnt    <= '0;
         rw     <= 1'b0;
         mack   <= 1'b0;
         ptr    <= '0;
         sda_oe <= 1'b0;
         we     <= 1'b0;
         widx   <= '0;
         wdata  <= '0;
      end else begin
         we <= 1'b0;
         if (start_det) begin
            st     <= ST_ADDR;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else if (stop_det) begin
            st     <= ST_IDLE;
            cnt    <= '0;
            sda_oe <= 1'b0;
         end else begin
            case (st)
               ST_ADDR, ST_REG, ST_WDAT: begin
                  if (scl_rise && cnt < CNT_FULL) begin
                     sh  <= {sh[DATA_W-2:0], sda_lvl};
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall && cnt == CNT_FULL) begin
                     cnt <= '0;
                     if (st == ST_ADDR) begin
                        if (sh[DATA_W-1:1] == dev_addr) begin
                           rw     <= sh[0];
                           sda_oe <= 1'b1;
                           st     <= ST_ADDR_ACK;
                        end else begin
                           st <= ST_IDLE;
                        end
                     end else if (st == ST_REG) begin
                        ptr    <= IDX_W'(sh);
                        sda_oe <= 1'b1;
                        st     <= ST_REG_ACK;
                     end else begin
                        we     <= 1'b1;
                        widx   <= ptr;
                        wdata  <= sh;
                        ptr    <= ptr + 1'b1;
                        sda_oe <= 1'b1;
                        st     <= ST_WDAT_ACK;
                     end
                  end
               end
               ST_ADDR_ACK, ST_REG_ACK, ST_WDAT_ACK: begin
                  if (scl_fall) begin
                     cnt <= '0;
                     if (st == ST_ADDR_ACK && rw) begin
                        txb    <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                        st     <= ST_RDAT;
                     end else begin
                        sda_oe <= 1'b0;
                        st     <= (st == ST_ADDR_ACK) ? ST_REG : ST_WDAT;
                     end
                  end
               end
               ST_RDAT: begin
                  if (scl_rise) begin
                     cnt <= cnt + 1'b1;
                  end else if (scl_fall) begin
                     if (cnt == CNT_FULL) begin
                        sda_oe <= 1'b0;
                        ptr    <= ptr + 1'b1;
                        st     <= ST_RACK;
                     end else begin
                        txb    <= {txb[DATA_W-2:0], 1'b0};
                        sda_oe <= ~txb[DATA_W-2];
                     end
                  end
               end
               ST_RACK: begin
                  if (scl_rise) begin
                     mack <= ~sda_lvl;
                  end else if (scl_fall) begin
                     cnt <= '0;
                     if (mack) begin
                        txb    <= rd_data;
                        sda_oe <= ~rd_data[DATA_W-1];
                        st     <= ST_RDAT;
                     end else begin
                        st <= ST_IDLE;
                     end
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign idle    = (st == ST_IDLE);
   assign rd_mode = (st == ST_RDAT) || (st == ST_RACK);
endmodule

// File: rtl/i2c_regbank_target.sv
module i2c_regbank_target #(
   parameter int ADDR_W      = 7,
   parameter int DATA_W      = 8,
   parameter int DEPTH       = 256,
   parameter int SYNC_STAGES = 2,
   parameter bit GLITCH_FILT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] dev_addr,
   output logic              sda_oe
);
   localparam int IDX_W = $clog2(DEPTH);

   generate
      if (ADDR_W + 1 != DATA_W) begin : g_bad_addr_w
         $error("i2c_regbank_target: address plus direction bit must fill one byte");
      end
      if (DEPTH != (1 << DATA_W)) begin : g_bad_depth
         $error("i2c_regbank_target: DEPTH must equal 2**DATA_W so the index byte covers it");
      end
   endgenerate

   logic scl_s, scl_r, scl_f;
   logic sda_s, sda_r, sda_f;
   logic start_det, stop_det;
   logic we, idle, rd_mode;
   logic [IDX_W-1:0]  widx, ptr;
   logic [DATA_W-1:0] wdata, rdata;

   i2c_line_sync #(.STAGES(SYNC_STAGES), .FILTER(GLITCH_FILT)) u_scl_sync (
      .clk(clk), .rst_n(rst_n), .pin(scl_i), .lvl(scl_s), .rise(scl_r), .fall(scl_f));
   i2c_line_sync #(.STAGES(SYNC_STAGES), .FILTER(GLITCH_FILT)) u_sda_sync (
      .clk(clk), .rst_n(rst_n), .pin(sda_i), .lvl(sda_s), .rise(sda_r), .fall(sda_f));

   assign start_det = sda_f & scl_s;
   assign stop_det  = sda_r & scl_s;

   i2c_tgt_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_fsm (
      .clk(clk), .rst_n(rst_n), .scl_rise(scl_r), .scl_fall(scl_f), .sda_lvl(sda_s),
      .start_det(start_det), .stop_det(stop_det), .dev_addr(dev_addr), .rd_data(rdata),
      .we(we), .widx(widx), .wdata(wdata), .ptr(ptr), .sda_oe(sda_oe),
      .idle(idle), .rd_mode(rd_mode));

   i2c_regbank #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_bank (
      .clk(clk), .rst_n(rst_n), .we(we), .widx(widx), .wdata(wdata),
      .ridx(ptr), .rdata(rdata));
endmodule

// File: rtl/i2c_regbank_target_chk.sv
module i2c_regbank_target_chk #(
   parameter int IDX_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             scl_lvl,
   input logic             start_det,
   input logic             stop_det,
   input logic             sda_oe,
   input logic             we,
   input logic [IDX_W-1:0] widx,
   input logic [IDX_W-1:0] ptr,
   input logic             idle,
   input logic             rd_mode
);
   a_r8_oe_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_oe) |-> !scl_lvl);

   a_r5_ptr_steps_on_store: assert property (@(posedge clk) disable iff (!rst_n)
      we |-> (ptr == IDX_W'(widx + 1'b1)));

   a_r9_start_releases: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_oe);

   a_r9_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
      stop_det |=> (!sda_oe && idle));

   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      idle |-> (!sda_oe && !we));

   a_r6_no_store_in_read: assert property (@(posedge clk) disable iff (!rst_n)
      rd_mode |-> !we);
endmodule

bind i2c_regbank_target i2c_regbank_target_chk #(.IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .scl_lvl(scl_s), .start_det(start_det),
   .stop_det(stop_det), .sda_oe(sda_oe), .we(we), .widx(widx), .ptr(ptr),
   .idle(idle), .rd_mode(rd_mode));

// File: tb/i2c_regbank_target_tb.sv
module i2c_regbank_target_tb;
   localparam int Q = 10;
   localparam logic [6:0] MY_ADDR = 7'h50;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl = 1'b1;
   logic m_low = 1'b0;
   logic sda_oe;
   logic sda_bus;

   int total = 0;
   int bad = 0;
   int cmp_bad = 0;
   logic cmp_en = 1'b0;
   logic cmp_exp = 1'b0;

   logic [7:0] ref_mem [256];
   logic [7:0] ref_ptr = 8'h00;

   always #4 clk = ~clk;

   assign sda_bus = ~(m_low | sda_oe);

   i2c_regbank_target u_dut (
      .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
      .dev_addr(MY_ADDR), .sda_oe(sda_oe));

   // reference comparison of the drive enable, every clock
   always @(negedge clk) begin
      if (cmp_en && sda_oe !== cmp_exp) cmp_bad = cmp_bad + 1;
   end

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      total = total + 1;
      if (!ok) begin
         bad = bad + 1;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic bus_start();
      m_low = 1'b1; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_rstart();
      m_low = 1'b0; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b1; tick(Q);
      scl = 1'b0;   tick(Q);
   endtask

   task automatic bus_stop();
      m_low = 1'b1; tick(Q);
      scl = 1'b1;   tick(Q);
      m_low = 1'b0; tick(Q);
   endtask

   task automatic clk_bit(input logic drive_low, input logic exp_oe, output logic smp);
      m_low = drive_low; tick(Q);
      scl = 1'b1; cmp_exp = exp_oe; cmp_en = 1'b1; tick(Q);
      smp = sda_bus; tick(Q);
      cmp_en = 1'b0; scl = 1'b0; tick(Q);
   endtask

   task automatic wr_byte(input logic [7:0] b, input logic exp_ack, input string req);
      logic s;
      cmp_bad = 0;
      for (int i = 7; i >= 0; i--) clk_bit(~b[i], 1'b0, s);
      clk_bit(1'b0, exp_ack, s);
      m_low = 1'b0;
      check(cmp_bad == 0 && s == ~exp_ack, req, "acknowledge", int'(s), int'(~exp_ack));
   endtask

   task automatic rd_byte(input logic [7:0] exp, input logic m_ack, input string req);
      logic s;
      logic [7:0] got;
      got = '0;
      cmp_bad = 0;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b0, ~exp[i], s);
         got[i] = s;
      end
      clk_bit(m_ack, 1'b0, s);
      m_low = 1'b0;
      check(got == exp && cmp_bad == 0, req, "read byte", int'(got), int'(exp));
   endtask

   // write transfer: index byte then n data bytes (model updated alongside)
   task automatic xfer_write(input logic [7:0] idx, input int n,
                             input logic [7:0] d0, input logic [7:0] d1);
      bus_start();
      wr_byte({MY_ADDR, 1'b0}, 1'b1, "R2");
      wr_byte(idx, 1'b1, "R4");
      ref_ptr = idx;
      for (int k = 0; k < n; k++) begin
         wr_byte(k == 0 ? d0 : d1, 1'b1, "R5");
         ref_mem[ref_ptr] = (k == 0) ? d0 : d1;
         ref_ptr = ref_ptr + 8'd1;
      end
      bus_stop();
   endtask

   task automatic read_body(input int n, input string req);
      wr_byte({MY_ADDR, 1'b1}, 1'b1, "R2");
      for (int k = 0; k < n; k++) begin
         rd_byte(ref_mem[ref_ptr], (k != n - 1), req);
         ref_ptr = ref_ptr + 8'd1;
      end
      tick(2);
      check(sda_oe == 1'b0, "R7", "released after controller NACK", int'(sda_oe), 0);
      bus_stop();
   endtask

   task automatic idx_then_read(input logic [7:0] idx, input int n, input string req);
      bus_start();
      wr_byte({MY_ADDR, 1'b0}, 1'b1, "R2");
      wr_byte(idx, 1'b1, "R4");
      ref_ptr = idx;
      bus_rstart();
      read_body(n, req);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      total = total + 1;
      bad = bad + 1;
      $display("FAIL watchdog run did not complete actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      logic s;
      for (int i = 0; i < 256; i++) ref_mem[i] = 8'h00;
      tick(5);
      check(sda_oe == 1'b0, "R1", "oe during reset", int'(sda_oe), 0);
      rst_n = 1'b1;
      tick(10);
      check(sda_oe == 1'b0, "R1", "oe after reset", int'(sda_oe), 0);

      // R1 / R10: read with no index after reset starts at 0 and returns 0
      bus_start();
      read_body(1, "R1");

      // R4 / R5: write two bytes at 0x10
      xfer_write(8'h10, 2, 8'hA5, 8'h3C);
      // R6 / R7: repeated START read burst
      idx_then_read(8'h10, 2, "R6");

      // R5: pointer wrap from 0xFF to 0x00
      xfer_write(8'hFF, 2, 8'h11, 8'h22);
      idx_then_read(8'hFF, 2, "R5");

      // R3: foreign address, following bytes ignored
      bus_start();
      wr_byte({7'h51, 1'b0}, 1'b0, "R3");
      wr_byte(8'h10, 1'b0, "R3");
      wr_byte(8'h99, 1'b0, "R3");
      bus_stop();
      idx_then_read(8'h10, 1, "R3");

      // R9: START in the middle of a data byte
      bus_start();
      wr_byte({MY_ADDR, 1'b0}, 1'b1, "R2");
      wr_byte(8'h20, 1'b1, "R4");
      ref_ptr = 8'h20;
      cmp_bad = 0;
      for (int i = 0; i < 3; i++) clk_bit(1'b0, 1'b0, s);
      check(cmp_bad == 0, "R8", "released during partial byte", cmp_bad, 0);
      bus_rstart();
      read_body(1, "R9");
      check(sda_oe == 1'b0, "R9", "released after STOP", int'(sda_oe), 0);

      // R10: pointer persists across separate transfers
      xfer_write(8'h30, 2, 8'h5A, 8'h6B);
      xfer_write(8'h30, 0, 8'h00, 8'h00);
      bus_start();
      read_body(2, "R10");
      bus_start();
      read_body(1, "R10");

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule